// File: doc/BRIEF.md
# Vectored Interrupt Controller for a Small Microcontroller Core

This block arbitrates five interrupt sources for an 8-bit microcontroller core. The sources are two external pins, a timer overflow, a periodic time-base tick and a real-time-clock tick. Each source has an enable bit and a pending flag. These bits live in two byte-wide control registers, which software reads and writes through a simple select/write port. The external pins pass through a synchronizer and an edge detector. Each pin can be set to react to falling edges, rising edges or both.

When a source may be serviced, the block raises a one-cycle call request with that source's fixed vector address. On that same clock edge it clears the serviced flag and the global enable. The core reports when the call has been taken, when a return-from-interrupt executes, and when its call stack is full. Any full stack holds back every acknowledge. Requests that arrive while interrupts are masked stay pending. Software can set the global enable again inside a service routine, which allows nested interrupts.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: After reset, both control registers read 0x00 and call_req is low.
- R2: Register 0 (reg_sel=0) has this layout: bit0 global enable, bit1/bit2/bit3 enables for external 0, external 1 and timer, bit4/bit5/bit6 flags for external 0, external 1 and timer. Bit7 always reads 0, and writes to it have no effect.
- R3: Register 1 (reg_sel=1) has this layout: bit1 time-base enable, bit2 real-time-clock enable, bit5 time-base flag, bit6 real-time-clock flag. Bits 0, 3, 4 and 7 always read 0.
- R4: An external pin sets its flag on the edge chosen by its two-bit mode. ext_mode[1:0] controls pin 0 and ext_mode[3:2] controls pin 1. The codes are 00 falling, 01 rising, 1x both. An edge of the other direction leaves the flag unchanged. The flag is visible at most 4 cycles after the pin changes.
- R5: A one-cycle pulse on tmr_ovf, tb_tick or rtc_tick sets the timer, time-base or real-time-clock flag.
- R6: A source is acknowledged only when four conditions all hold: its enable is 1, the global enable is 1, its flag is 1, and stack_full is 0. A set flag whose enable is 0 stays pending and causes no call.
- R7: An acknowledge clears the serviced flag and the global enable on the same edge. The enable bits keep their values.
- R8: The vectors are 0x04 for external 0, 0x08 for external 1, 0x0C for the timer, 0x14 for the time base and 0x18 for the real-time clock.
- R9: When several sources can be acknowledged together, the one with the lowest vector is served first.
- R10: Flags set while the global enable is 0 remain pending and are served once it is set.
- R11: A reti pulse sets the global enable. A software write that sets it during service allows a nested call.
- R12: A hardware flag set in the same cycle as a software write of 0 to that flag leaves the flag at 1.
- R13: call_req is high for exactly one cycle per acknowledge. No further call_req occurs until call_taken has been seen.
- R14: While stack_full is 1, no call_req is raised. A pending request is served after stack_full falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 selects register 0, 1 selects register 1 |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| ext_pin | input | 2 | External interrupt pins |
| ext_mode | input | 4 | Edge mode per pin, two bits each |
| tmr_ovf | input | 1 | Timer overflow pulse |
| tb_tick | input | 1 | Time-base tick pulse |
| rtc_tick | input | 1 | Real-time-clock tick pulse |
| stack_full | input | 1 | Core call stack is full |
| call_taken | input | 1 | Core has taken the requested call |
| reti | input | 1 | Return-from-interrupt executed |
| call_req | output | 1 | One-cycle call request |
| call_vec | output | 8 | Vector address, valid with call_req |

## Verification
The arbiter is exercised with one source pending alone, which shows that each vector is correct. It is also exercised with all five sources pending at once and drained one reti at a time, which shows the priority order and that only the serviced flag is cleared. A flag that is set while its enable is 0, and a request raised while the stack is full, show that each acknowledge condition gates the call on its own. The edge detector is driven with rising and falling transitions under each mode code. A software clear is made to collide with a tick, and a nested call is attempted both before and after call_taken. Together these separate set-wins-over-clear behaviour and the one-call-at-a-time hold from simple masking.

// File: rtl/mcu_irq_pkg.sv
package mcu_irq_pkg;

    localparam int NSRC   = 5;
    localparam int DATA_W = 8;
    localparam int VEC_W  = 8;
    localparam int NPIN   = 2;

    typedef enum logic [2:0] {
        SRC_EXT0 = 3'd0,
        SRC_EXT1 = 3'd1,
        SRC_TMR  = 3'd2,
        SRC_TB   = 3'd3,
        SRC_RTC  = 3'd4
    } src_e;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_ANY  = 2'b10
    } edge_mode_e;

    // bit positions, register 0
    localparam int R0_GIE  = 0;
    localparam int R0_EN0  = 1;
    localparam int R0_EN1  = 2;
    localparam int R0_ENT  = 3;
    localparam int R0_FL0  = 4;
    localparam int R0_FL1  = 5;
    localparam int R0_FLT  = 6;
    // bit positions, register 1
    localparam int R1_ENB  = 1;
    localparam int R1_ENR  = 2;
    localparam int R1_FLB  = 5;
    localparam int R1_FLR  = 6;

    typedef struct packed {
        logic            gie;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flag;
    } irq_state_t;

    function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx);
        logic [VEC_W-1:0] v;
        case (idx)
            0:       v = 8'h04;
            1:       v = 8'h08;
            2:       v = 8'h0C;
            3:       v = 8'h14;
            default: v = 8'h18;
        endcase
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_r0(input irq_state_t s);
        logic [DATA_W-1:0] r;
        r = '0;
        r[R0_GIE] = s.gie;
        r[R0_EN0] = s.en[SRC_EXT0];
        r[R0_EN1] = s.en[SRC_EXT1];
        r[R0_ENT] = s.en[SRC_TMR];
        r[R0_FL0] = s.flag[SRC_EXT0];
        r[R0_FL1] = s.flag[SRC_EXT1];
        r[R0_FLT] = s.flag[SRC_TMR];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_r1(input irq_state_t s);
        logic [DATA_W-1:0] r;
        r = '0;
        r[R1_ENB] = s.en[SRC_TB];
        r[R1_ENR] = s.en[SRC_RTC];
        r[R1_FLB] = s.flag[SRC_TB];
        r[R1_FLR] = s.flag[SRC_RTC];
        return r;
    endfunction

endpackage

// File: rtl/mcu_irq_edge.sv
module mcu_irq_edge
    import mcu_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  logic [1:0] mode,
    output logic       hit
);
    localparam int HIST = SYNC_STAGES + 1;

    logic [HIST-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[HIST-2:0], pin};
    end

    logic now_lvl, old_lvl, rise, fall;
    assign now_lvl = sh[HIST-2];
    assign old_lvl = sh[HIST-1];
    assign rise    = now_lvl & ~old_lvl;
    assign fall    = ~now_lvl & old_lvl;

    always_comb begin
        case (mode)
            EDGE_FALL: hit = fall;
            EDGE_RISE: hit = rise;
            default:   hit = rise | fall;
        endcase
    end
endmodule

// File: rtl/mcu_irq_regs.sv
module mcu_irq_regs
    import mcu_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   hw_set,
    input  logic              ack,
    input  logic [NSRC-1:0]   grant,
    input  logic              reti,
    output irq_state_t        st,
    output logic [DATA_W-1:0] rdata
);
    irq_state_t nxt;

    always_comb begin
        nxt = st;
        if (wr && !sel) begin
            nxt.gie            = wdata[R0_GIE];
            nxt.en[SRC_EXT0]   = wdata[R0_EN0];
            nxt.en[SRC_EXT1]   = wdata[R0_EN1];
            nxt.en[SRC_TMR]    = wdata[R0_ENT];
            nxt.flag[SRC_EXT0] = wdata[R0_FL0];
            nxt.flag[SRC_EXT1] = wdata[R0_FL1];
            nxt.flag[SRC_TMR]  = wdata[R0_FLT];
        end
        if (wr && sel) begin
            nxt.en[SRC_TB]     = wdata[R1_ENB];
            nxt.en[SRC_RTC]    = wdata[R1_ENR];
            nxt.flag[SRC_TB]   = wdata[R1_FLB];
            nxt.flag[SRC_RTC]  = wdata[R1_FLR];
        end
        if (reti) nxt.gie = 1'b1;
        if (ack) begin
            nxt.gie  = 1'b0;
            nxt.flag = nxt.flag & ~grant;
        end
        nxt.flag = nxt.flag | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    assign rdata = sel ? pack_r1(st) : pack_r0(st);
endmodule

// File: rtl/mcu_irq_arb.sv
module mcu_irq_arb
    import mcu_irq_pkg::*;
(
    input  irq_state_t       st,
    input  logic             stack_full,
    input  logic             hold,
    output logic             valid,
    output logic [NSRC-1:0]  grant,
    output logic [VEC_W-1:0] vec
);
    logic [NSRC-1:0] pend;
    assign pend = st.flag & st.en;

    always_comb begin
        grant = '0;
        vec   = '0;
        valid = 1'b0;
        if (st.gie && !stack_full && !hold) begin
            for (int i = NSRC - 1; i >= 0; i--) begin
                if (pend[i]) begin
                    grant = '0;
                    grant[i] = 1'b1;
                    vec   = vec_of(i);
                    valid = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl
    import mcu_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPIN-1:0]   ext_pin,
    input  logic [2*NPIN-1:0] ext_mode,
    input  logic              tmr_ovf,
    input  logic              tb_tick,
    input  logic              rtc_tick,
    input  logic              stack_full,
    input  logic              call_taken,
    input  logic              reti,
    output logic              call_req,
    output logic [VEC_W-1:0]  call_vec
);
    logic [NPIN-1:0]  pin_hit;
    logic [NSRC-1:0]  hw_set;
    logic [NSRC-1:0]  grant;
    logic [VEC_W-1:0] arb_vec;
    logic             ack;
    logic             call_busy;
    irq_state_t       st;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        mcu_irq_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst  (rst),
            .pin  (ext_pin[p]),
            .mode (ext_mode[2*p +: 2]),
            .hit  (pin_hit[p])
        );
    end

    assign hw_set = {rtc_tick, tb_tick, tmr_ovf, pin_hit};

    mcu_irq_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .hw_set (hw_set),
        .ack    (ack),
        .grant  (grant),
        .reti   (reti),
        .st     (st),
        .rdata  (reg_rdata)
    );

    mcu_irq_arb u_arb (
        .st         (st),
        .stack_full (stack_full),
        .hold       (call_busy),
        .valid      (ack),
        .grant      (grant),
        .vec        (arb_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            call_req  <= 1'b0;
            call_vec  <= '0;
            call_busy <= 1'b0;
        end else begin
            call_req <= ack;
            if (ack) call_vec <= arb_vec;
            if (ack)             call_busy <= 1'b1;
            else if (call_taken) call_busy <= 1'b0;
        end
    end
endmodule

// File: rtl/mcu_irq_ctrl_chk.sv
module mcu_irq_ctrl_chk
    import mcu_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             call_req,
    input logic [VEC_W-1:0] call_vec,
    input logic             call_taken,
    input logic             stack_full,
    input logic             busy,
    input logic             gie,
    input logic [NSRC-1:0]  en,
    input logic [NSRC-1:0]  flag
);
    // R13
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        call_req |=> !call_req);

    // R13
    hold_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !call_taken) |=> !call_req);

    // R7
    gie_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        call_req |-> !gie);

    // R14
    stack_block_chk: assert property (@(posedge clk) disable iff (rst)
        stack_full |=> !call_req);

    // R6
    masked_chk: assert property (@(posedge clk) disable iff (rst)
        !gie |=> !call_req);

    // R8
    vec_legal_chk: assert property (@(posedge clk) disable iff (rst)
        call_req |-> (call_vec == 8'h04 || call_vec == 8'h08 || call_vec == 8'h0C ||
                      call_vec == 8'h14 || call_vec == 8'h18));

    // R9
    top_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (gie && en[0] && flag[0] && !stack_full && !busy) |=> (call_req && call_vec == 8'h04));
endmodule

bind mcu_irq_ctrl mcu_irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .call_req   (call_req),
    .call_vec   (call_vec),
    .call_taken (call_taken),
    .stack_full (stack_full),
    .busy       (call_busy),
    .gie        (st.gie),
    .en         (st.en),
    .flag       (st.flag)
);

// File: tb/sim_mcu_irq_ctrl.sv
module sim_mcu_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] ext_pin = '0;
    logic [3:0] ext_mode = '0;
    logic       tmr_ovf = 0, tb_tick = 0, rtc_tick = 0;
    logic       stack_full = 0, call_taken = 0, reti = 0;
    logic       call_req;
    logic [7:0] call_vec;

    int tests = 0, fails = 0, pulses = 0, cyc = 0;
    logic [7:0] last_vec = '0;

    always #10 clk = ~clk;

    mcu_irq_ctrl u0 (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
        .ext_mode(ext_mode), .tmr_ovf(tmr_ovf), .tb_tick(tb_tick),
        .rtc_tick(rtc_tick), .stack_full(stack_full), .call_taken(call_taken),
        .reti(reti), .call_req(call_req), .call_vec(call_vec)
    );

    always @(negedge clk) if (!rst && call_req) begin
        pulses++;
        last_vec = call_vec;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic s, output logic [7:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_taken();
        @(negedge clk); call_taken = 1'b1;
        @(negedge clk); call_taken = 1'b0;
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    task automatic clear_all();
        wr(0, 8'h00); wr(1, 8'h00);
        pulse_taken();
        idle(2);
        pulses = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(0, d); chk("R1 reg0", d, 8'h00);
        rd(1, d); chk("R1 reg1", d, 8'h00);
        chk("R1 call_req", call_req, 1'b0);
    endtask

    task automatic t_layout();
        logic [7:0] d;
        wr(0, 8'hFE); rd(0, d); chk("R2 reg0 readback", d, 8'h7E);
        wr(1, 8'hFF); rd(1, d); chk("R3 reg1 readback", d, 8'h66);
        idle(3); chk("R10 no call while masked", pulses, 0);
        clear_all();
    endtask

    task automatic t_edges();
        logic [7:0] d;
        ext_mode = 4'b0001;              // pin0 rising, pin1 falling
        idle(2);
        ext_pin[1] = 1'b1; idle(4);
        rd(0, d); chk("R4 pin1 rise ignored in fall mode", d, 8'h00);
        ext_pin[1] = 1'b0; idle(4);
        rd(0, d); chk("R4 pin1 fall sets flag", d, 8'h20);
        ext_pin[0] = 1'b1; idle(4);
        rd(0, d); chk("R4 pin0 rise sets flag", d, 8'h30);
        wr(0, 8'h00);
        ext_pin[0] = 1'b0; idle(4);
        rd(0, d); chk("R4 pin0 fall ignored in rise mode", d, 8'h00);
        ext_mode = 4'b0010; idle(2);     // pin0 both
        ext_pin[0] = 1'b1; idle(4);
        rd(0, d); chk("R4 both mode rise", d, 8'h10);
        wr(0, 8'h00);
        ext_pin[0] = 1'b0; idle(4);
        rd(0, d); chk("R4 both mode fall", d, 8'h10);
        clear_all();
    endtask

    task automatic t_ticks();
        logic [7:0] d;
        @(negedge clk); tb_tick = 1; @(negedge clk); tb_tick = 0;
        rd(1, d); chk("R5 tb flag", d, 8'h20);
        @(negedge clk); tmr_ovf = 1; @(negedge clk); tmr_ovf = 0;
        rd(0, d); chk("R5 timer flag", d, 8'h40);
        wr(1, 8'h40);
        @(negedge clk);
        reg_sel = 1; reg_wdata = 8'h00; reg_wr = 1; rtc_tick = 1;
        @(negedge clk);
        reg_wr = 0; rtc_tick = 0;
        rd(1, d); chk("R12 hw set beats sw clear", d, 8'h40);
        clear_all();
    endtask

    task automatic t_basic_ack();
        logic [7:0] d;
        wr(0, 8'h09);
        @(negedge clk); tmr_ovf = 1; @(negedge clk); tmr_ovf = 0;
        idle(3);
        chk("R13 single pulse", pulses, 1);
        chk("R8 timer vector", last_vec, 8'h0C);
        rd(0, d); chk("R7 flag and gie cleared, enable kept", d, 8'h08);
        pulse_taken();
        clear_all();
        wr(0, 8'h41); idle(4);
        chk("R6 disabled source no call", pulses, 0);
        rd(0, d); chk("R6 disabled flag pending", d, 8'h41);
        clear_all();
    endtask

    task automatic serve_next(input logic [7:0] v, input string req);
        pulses = 0;
        pulse_taken();
        pulse_reti();
        idle(3);
        chk(req, pulses, 1);
        chk(req, last_vec, v);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        wr(0, 8'h7E); wr(1, 8'h66);
        pulses = 0;
        wr(0, 8'h7F);
        idle(3);
        chk("R9 first served", pulses, 1);
        chk("R9 ext0 first", last_vec, 8'h04);
        rd(0, d); chk("R7 only ext0 flag cleared", d, 8'h6E);
        serve_next(8'h08, "R11 reti then ext1");
        serve_next(8'h0C, "R9 then timer");
        serve_next(8'h14, "R9 then time base");
        serve_next(8'h18, "R9 then rtc");
        rd(0, d); chk("R10 reg0 drained", d, 8'h0E);
        rd(1, d); chk("R10 reg1 drained", d, 8'h06);
        clear_all();
    endtask

    task automatic t_stack();
        stack_full = 1'b1;
        wr(1, 8'h22); wr(0, 8'h01);
        idle(6);
        chk("R14 held while full", pulses, 0);
        stack_full = 1'b0;
        idle(3);
        chk("R14 served after release", pulses, 1);
        chk("R14 vector", last_vec, 8'h14);
        clear_all();
    endtask

    task automatic t_nest();
        wr(1, 8'h04); wr(0, 8'h09);
        @(negedge clk); tmr_ovf = 1; @(negedge clk); tmr_ovf = 0;
        idle(3);
        chk("R13 first call", pulses, 1);
        @(negedge clk); rtc_tick = 1; @(negedge clk); rtc_tick = 0;
        wr(0, 8'h09);
        idle(5);
        chk("R13 no call before taken", pulses, 1);
        pulse_taken();
        idle(3);
        chk("R11 nested call", pulses, 2);
        chk("R11 nested vector", last_vec, 8'h18);
        clear_all();
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_layout();
        t_edges();
        t_ticks();
        t_basic_ack();
        t_priority();
        t_stack();
        t_nest();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule